// File: doc/BRIEF.md
# Product-Term Logic Cell with Configurable Storage

This block is a single logic cell driven by a programmable AND-OR array. A set of product terms is formed over a shared input vector. A per-cell select mask picks which of those terms are ORed into the sum. The sum can then be XORed with a dedicated extra product term and optionally inverted. The resulting function drives the cell output directly, or it drives the output through a storage element.

The storage element can act as a D flip-flop, a T flip-flop or a transparent latch. It can trigger on one clock edge of selectable polarity or on both edges. Its clock, asynchronous set, asynchronous reset and clock enable each come from a selectable source. An input-register mode loads the storage element from a direct pin input instead of the logic. In that mode the combinational result still reaches the cell output. All selection is held in a static configuration word.

Top module: `pla_logic_cell`

## Requirements
- R1: Term p is the AND of `sig_in[i]` for every set bit `t_mask[p*N_IN+i]` and of `~sig_in[i]` for every set bit `c_mask[p*N_IN+i]`. A term with no literal is 1. The sum is the OR of all terms whose `or_sel` bit is set.
- R2: When `cfg[0]` is 1, the sum is XORed with the extra term built from `x_tmask`/`x_cmask` in the same way as in R1. When `cfg[1]` is 1, the result is then inverted.
- R3: With `cfg[2]`=0, `cell_out` follows the logic result with no clock. With `cfg[2]`=1, `cell_out` shows the stored value.
- R4: In D mode (`cfg[4:3]`=0), single edge (`cfg[5]`=0), the storage loads its data on the rising edge of the selected clock when `cfg[6]`=0, and on the falling edge when `cfg[6]`=1.
- R5: In T mode (`cfg[4:3]`=1), the stored value inverts on each active edge while the data is 1 and holds while it is 0.
- R6: In latch mode (`cfg[4:3]`=2) with `cfg[6]`=0, the storage passes its data while the selected clock is high and holds it while the clock is low.
- R7: With `cfg[5]`=1, the D and T behaviour happens on both edges of the selected clock.
- R8: With `cfg[14]`=1 in D mode, the storage holds across active edges while term `PT_CE` is 0. In T mode the enable is ignored.
- R9: `cfg[9:7]` selects the clock. Values 0 to 2 select `clk_g[0]` to `clk_g[2]`, 3 selects `ct_clk`, and 4 selects term `PT_CLK`. Non-selected clocks have no effect.
- R10: `cfg[11:10]` selects the set source and `cfg[13:12]` the reset source. Value 0 means none, 1 the local term (`PT_SET`/`PT_RST`), 2 the shared `ct_set`/`ct_rst`, and 3 `gsr`. Both act without a clock. Reset wins when set and reset are active together.
- R11: With `cfg[15]`=1, the storage data comes from `pin_in` and `reg_out` shows it, while `cell_out` carries the logic result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_g | input | 3 | Global clocks |
| ct_clk | input | 1 | Shared control-term clock |
| ct_set | input | 1 | Shared control-term set |
| ct_rst | input | 1 | Shared control-term reset |
| gsr | input | 1 | Global set/reset |
| sig_in | input | N_IN | Array input vector |
| pin_in | input | 1 | Direct pin input for input-register mode |
| t_mask | input | N_PT*N_IN | True-literal masks, N_IN bits per term |
| c_mask | input | N_PT*N_IN | Complement-literal masks, N_IN bits per term |
| or_sel | input | N_PT | Terms summed into this cell |
| x_tmask | input | N_IN | True-literal mask of the XOR term |
| x_cmask | input | N_IN | Complement-literal mask of the XOR term |
| cfg | input | 16 | Static configuration word |
| cell_out | output | 1 | Cell result |
| reg_out | output | 1 | Storage element value |

## Verification
The logic result, the latch path and the asynchronous set and reset have no cycle delay. The bench checks each of them one time unit after it changes the stimulus. The edge-triggered paths change only at an edge of the selected clock. For those, the bench first checks that the output has not moved before the edge and then checks the new value one time unit after the edge. For the one scenario clocked by `clk_g[0]`, the bench drives the inputs on a falling edge and checks at the next falling edge, so the update from the rising edge lies between the two samples.

// File: rtl/pla_logic_cell.sv
module pla_logic_cell #(
  parameter int N_IN   = 40,
  parameter int N_PT   = 56,
  parameter int PT_CLK = 52,
  parameter int PT_SET = 53,
  parameter int PT_RST = 54,
  parameter int PT_CE  = 55
) (
  input  logic [2:0]           clk_g,
  input  logic                 ct_clk,
  input  logic                 ct_set,
  input  logic                 ct_rst,
  input  logic                 gsr,
  input  logic [N_IN-1:0]      sig_in,
  input  logic                 pin_in,
  input  logic [N_PT*N_IN-1:0] t_mask,
  input  logic [N_PT*N_IN-1:0] c_mask,
  input  logic [N_PT-1:0]      or_sel,
  input  logic [N_IN-1:0]      x_tmask,
  input  logic [N_IN-1:0]      x_cmask,
  input  logic [15:0]          cfg,
  output logic                 cell_out,
  output logic                 reg_out
);
  logic [N_PT-1:0] pt;

  genvar p;
  generate
    for (p = 0; p < N_PT; p++) begin : g_term
      assign pt[p] = &((~t_mask[p*N_IN +: N_IN] | sig_in) &
                       (~c_mask[p*N_IN +: N_IN] | ~sig_in));
    end
  endgenerate

  logic       xor_en, inv, reg_en, dual, pol, ce_en, in_reg;
  logic [1:0] mode, set_src, rst_src;
  logic [2:0] clk_src;
  assign xor_en  = cfg[0];
  assign inv     = cfg[1];
  assign reg_en  = cfg[2];
  assign mode    = cfg[4:3];
  assign dual    = cfg[5];
  assign pol     = cfg[6];
  assign clk_src = cfg[9:7];
  assign set_src = cfg[11:10];
  assign rst_src = cfg[13:12];
  assign ce_en   = cfg[14];
  assign in_reg  = cfg[15];

  logic is_t, is_lat;
  assign is_t   = (mode == 2'd1);
  assign is_lat = (mode == 2'd2);

  logic xterm, sum, comb, d_in;
  assign xterm = &((~x_tmask | sig_in) & (~x_cmask | ~sig_in));
  assign sum   = |(pt & or_sel);
  assign comb  = (sum ^ (xor_en & xterm)) ^ inv;
  assign d_in  = in_reg ? pin_in : comb;

  logic clk_raw, clk_eff, aset, arst;
  always_comb begin
    case (clk_src)
      3'd0:    clk_raw = clk_g[0];
      3'd1:    clk_raw = clk_g[1];
      3'd2:    clk_raw = clk_g[2];
      3'd3:    clk_raw = ct_clk;
      3'd4:    clk_raw = pt[PT_CLK];
      default: clk_raw = 1'b0;
    endcase
    case (set_src)
      2'd1:    aset = pt[PT_SET];
      2'd2:    aset = ct_set;
      2'd3:    aset = gsr;
      default: aset = 1'b0;
    endcase
    case (rst_src)
      2'd1:    arst = pt[PT_RST];
      2'd2:    arst = ct_rst;
      2'd3:    arst = gsr;
      default: arst = 1'b0;
    endcase
  end
  assign clk_eff = clk_raw ^ pol;

  logic q_pos, q_neg, q_lat, ce_ok, base_p, nxt_p, nxt_n;
  assign ce_ok  = !(ce_en && !is_t && !is_lat) || pt[PT_CE];
  assign base_p = dual ? q_neg : q_pos;
  assign nxt_p  = is_t ? (base_p ^ d_in) : (ce_ok ? d_in : base_p);
  assign nxt_n  = is_t ? (q_pos ^ d_in)  : (ce_ok ? d_in : q_pos);

  always_ff @(posedge clk_eff or posedge arst or posedge aset) begin
    if (arst)      q_pos <= 1'b0;
    else if (aset) q_pos <= 1'b1;
    else           q_pos <= nxt_p;
  end

  always_ff @(negedge clk_eff or posedge arst or posedge aset) begin
    if (arst)      q_neg <= 1'b0;
    else if (aset) q_neg <= 1'b1;
    else           q_neg <= nxt_n;
  end

  always_latch begin
    if (arst)         q_lat <= 1'b0;
    else if (aset)    q_lat <= 1'b1;
    else if (clk_eff) q_lat <= d_in;
  end

  assign reg_out  = is_lat ? q_lat : ((dual && !clk_eff) ? q_neg : q_pos);
  assign cell_out = (reg_en && !in_reg) ? reg_out : comb;

  logic g0_edge;
  assign g0_edge = !is_lat && !dual && (clk_src == 3'd0) && !pol;

  p_dcap_r4: assert property (@(posedge clk_g[0]) disable iff (gsr)
    (g0_edge && !is_t && ce_ok) |=> (cfg != $past(cfg)) || (reg_out == $past(d_in)));

  p_toggle_r5: assert property (@(posedge clk_g[0]) disable iff (gsr)
    (g0_edge && is_t) |=> (cfg != $past(cfg)) || (reg_out == $past(reg_out ^ d_in)));

  p_ce_hold_r8: assert property (@(posedge clk_g[0]) disable iff (gsr)
    (g0_edge && !is_t && !ce_ok) |=> (cfg != $past(cfg)) || (reg_out == $past(reg_out)));

  p_reset_wins_r10: assert property (@(posedge clk_g[0]) disable iff (gsr)
    arst |-> !reg_out);

  p_set_r10: assert property (@(posedge clk_g[0]) disable iff (gsr)
    (aset && !arst) |-> reg_out);
endmodule

// File: tb/tb_pla_logic_cell.sv
module tb_pla_logic_cell;
  localparam int CLK_P = 10;
  localparam int NI = 40;
  localparam int NP = 56;

  logic g0 = 0, g1 = 0, g2 = 0;
  logic ct_clk = 0, ct_set = 0, ct_rst = 0, gsr = 1, pin_in = 0;
  logic [NI-1:0]    sig = '0;
  logic [NP*NI-1:0] t_mask = '0, c_mask = '0;
  logic [NP-1:0]    or_sel = '0;
  logic [NI-1:0]    x_tm = '0, x_cm = '0;
  logic [15:0]      cfg = {1'b0,1'b0,2'd3,2'd0,3'd1,1'b0,1'b0,2'd0,1'b1,1'b0,1'b0};
  logic cell_out, reg_out;
  int n_chk = 0, n_fail = 0;

  pla_logic_cell dut (
    .clk_g({g2, g1, g0}), .ct_clk(ct_clk), .ct_set(ct_set), .ct_rst(ct_rst),
    .gsr(gsr), .sig_in(sig), .pin_in(pin_in), .t_mask(t_mask), .c_mask(c_mask),
    .or_sel(or_sel), .x_tmask(x_tm), .x_cmask(x_cm), .cfg(cfg),
    .cell_out(cell_out), .reg_out(reg_out));

  always #(CLK_P/2) g0 = ~g0;

  function automatic logic [15:0] mk(input logic xe, iv, rg, input logic [1:0] md,
      input logic du, pl, input logic [2:0] cs, input logic [1:0] ss, rs,
      input logic ce, ir);
    return {ir, ce, rs, ss, cs, pl, du, md, rg, iv, xe};
  endfunction

  task automatic chk(input string rq, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", rq, act, exp);
    end
  endtask

  task automatic clear_masks();
    t_mask = '0; c_mask = '0; or_sel = '0; x_tm = '0; x_cm = '0; sig = '0;
  endtask

  task automatic lit(input int p, input int i, input bit neg);
    if (neg) c_mask[p*NI+i] = 1'b1;
    else     t_mask[p*NI+i] = 1'b1;
  endtask

  task automatic data_x0();
    clear_masks(); lit(0, 0, 0); or_sel[0] = 1'b1;
  endtask

  task automatic clr();
    ct_rst = 1; #1; ct_rst = 0; #1;
  endtask

  task automatic pg1();
    g1 = 1; #1; g1 = 0; #1;
  endtask

  task automatic t_reset();
    #3; chk("R10 gsr reset", reg_out, 1'b0);
    gsr = 0; #1;
  endtask

  task automatic t_sop();
    cfg = 16'h0; clear_masks();
    lit(0, 0, 0); lit(0, 1, 1); lit(5, 39, 0);
    or_sel[0] = 1; or_sel[5] = 1;
    sig = '0; #1; chk("R1 no term true", cell_out, 1'b0);
    sig = 40'h1; #1; chk("R1 x0&~x1", cell_out, 1'b1);
    sig = 40'h3; #1; chk("R1 complement literal blocks", cell_out, 1'b0);
    sig = '0; sig[39] = 1; #1; chk("R1 second term", cell_out, 1'b1);
    sig = '0; or_sel = '0; or_sel[7] = 1; #1; chk("R1 empty term is 1", cell_out, 1'b1);
    or_sel = '0; #1; chk("R3 comb follows without clock", cell_out, 1'b0);
  endtask

  task automatic t_xor();
    clear_masks(); lit(0, 0, 0); or_sel[0] = 1; x_tm[1] = 1;
    cfg = mk(1,0,0,0,0,0,0,0,0,0,0);
    sig = 40'h1; #1; chk("R2 xor 1^0", cell_out, 1'b1);
    sig = 40'h3; #1; chk("R2 xor 1^1", cell_out, 1'b0);
    sig = 40'h2; #1; chk("R2 xor 0^1", cell_out, 1'b1);
    cfg = mk(1,1,0,0,0,0,0,0,0,0,0); #1; chk("R2 xor then invert", cell_out, 1'b0);
    cfg = mk(0,1,0,0,0,0,0,0,0,0,0); sig = '0; #1; chk("R2 invert only", cell_out, 1'b1);
  endtask

  task automatic t_regsel();
    data_x0(); cfg = mk(0,0,1,0,0,0,1,0,2,0,0); #1; clr();
    sig[0] = 1; #1; chk("R3 registered output holds", cell_out, 1'b0);
    cfg = mk(0,0,0,0,0,0,1,0,2,0,0); #1; chk("R3 comb selected", cell_out, 1'b1);
  endtask

  task automatic t_d_g0();
    data_x0(); @(negedge g0); cfg = mk(0,0,1,0,0,0,0,0,2,0,0); #1; clr();
    @(negedge g0); sig[0] = 1; #1; chk("R4 no capture before edge", cell_out, 1'b0);
    @(negedge g0); #1; chk("R4 rising capture 1", cell_out, 1'b1);
    sig[0] = 0; @(negedge g0); #1; chk("R4 rising capture 0", cell_out, 1'b0);
  endtask

  task automatic t_d_fall();
    data_x0(); cfg = mk(0,0,1,0,0,1,1,0,2,0,0); #1; clr();
    sig[0] = 1; g1 = 1; #1; chk("R4 falling mode ignores rise", reg_out, 1'b0);
    g1 = 0; #1; chk("R4 falling capture", reg_out, 1'b1);
  endtask

  task automatic t_toggle();
    data_x0(); cfg = mk(0,0,1,1,0,0,1,0,2,0,0); #1; clr();
    sig[0] = 1; pg1(); chk("R5 toggle to 1", reg_out, 1'b1);
    pg1(); chk("R5 toggle to 0", reg_out, 1'b0);
    sig[0] = 0; pg1(); chk("R5 hold when T=0", reg_out, 1'b0);
    sig[0] = 1; pg1(); chk("R5 toggle again", reg_out, 1'b1);
  endtask

  task automatic t_latch();
    data_x0(); cfg = mk(0,0,1,2,0,0,1,0,2,0,0); #1; clr();
    g1 = 1; sig[0] = 1; #1; chk("R6 transparent 1", reg_out, 1'b1);
    sig[0] = 0; #1; chk("R6 transparent 0", reg_out, 1'b0);
    g1 = 0; #1; sig[0] = 1; #1; chk("R6 closed holds", reg_out, 1'b0);
    g1 = 1; #1; chk("R6 reopens", reg_out, 1'b1);
    g1 = 0; #1;
  endtask

  task automatic t_dual();
    data_x0(); cfg = mk(0,0,1,0,1,0,1,0,2,0,0); #1; clr();
    sig[0] = 1; g1 = 1; #1; chk("R7 D rise", reg_out, 1'b1);
    sig[0] = 0; g1 = 0; #1; chk("R7 D fall", reg_out, 1'b0);
    sig[0] = 1; g1 = 1; #1; chk("R7 D rise again", reg_out, 1'b1);
    g1 = 0; #1; sig[0] = 0; #1;
    cfg = mk(0,0,1,1,1,0,1,0,2,0,0); #1; clr();
    sig[0] = 1; g1 = 1; #1; chk("R7 T rise", reg_out, 1'b1);
    g1 = 0; #1; chk("R7 T fall", reg_out, 1'b0);
    g1 = 1; #1; chk("R7 T rise again", reg_out, 1'b1);
    g1 = 0; #1;
  endtask

  task automatic t_ce();
    data_x0(); lit(55, 2, 0);
    cfg = mk(0,0,1,0,0,0,1,0,2,1,0); #1; clr();
    sig[0] = 1; pg1(); chk("R8 CE low holds", reg_out, 1'b0);
    sig[2] = 1; pg1(); chk("R8 CE high loads", reg_out, 1'b1);
    sig = '0; cfg = mk(0,0,1,1,0,0,1,0,2,1,0); #1; clr();
    sig[0] = 1; pg1(); chk("R8 CE ignored in T mode", reg_out, 1'b1);
  endtask

  task automatic t_clksrc();
    data_x0(); cfg = mk(0,0,1,0,0,0,2,0,2,0,0); #1; clr();
    sig[0] = 1; pg1(); chk("R9 other clock ignored", reg_out, 1'b0);
    g2 = 1; #1; g2 = 0; #1; chk("R9 clk_g2 captures", reg_out, 1'b1);
    sig[0] = 0; cfg = mk(0,0,1,0,0,0,3,0,2,0,0); #1; clr();
    sig[0] = 1; g2 = 1; #1; g2 = 0; #1; chk("R9 ct_clk source ignores g2", reg_out, 1'b0);
    ct_clk = 1; #1; ct_clk = 0; #1; chk("R9 ct_clk captures", reg_out, 1'b1);
    data_x0(); lit(52, 3, 0); cfg = mk(0,0,1,0,0,0,4,0,2,0,0); #1; clr();
    sig[0] = 1; #1; chk("R9 term clock idle", reg_out, 1'b0);
    sig[3] = 1; #1; chk("R9 term clock captures", reg_out, 1'b1);
    sig = '0; #1;
  endtask

  task automatic t_setrst();
    data_x0(); lit(54, 4, 0); lit(53, 5, 0);
    cfg = mk(0,0,1,0,0,0,1,2,1,0,0); #1;
    sig[4] = 1; #1; chk("R10 local reset", reg_out, 1'b0);
    sig[4] = 0; #1;
    ct_set = 1; #1; chk("R10 shared set", reg_out, 1'b1);
    ct_set = 0; #1; chk("R10 set holds after release", reg_out, 1'b1);
    ct_set = 1; sig[4] = 1; #1; chk("R10 reset wins", reg_out, 1'b0);
    ct_set = 0; sig[4] = 0; #1;
    cfg = mk(0,0,1,0,0,0,1,1,2,0,0); #1;
    sig[5] = 1; #1; chk("R10 local set", reg_out, 1'b1);
    sig[5] = 0; #1;
    cfg = mk(0,0,1,0,0,0,1,0,2,0,0); #1; clr();
    ct_set = 1; #1; chk("R10 unselected set ignored", reg_out, 1'b0);
    ct_set = 0; #1;
    cfg = mk(0,0,1,0,0,0,1,3,0,0,0); #1;
    gsr = 1; #1; gsr = 0; #1; chk("R10 gsr as set", reg_out, 1'b1);
  endtask

  task automatic t_inreg();
    data_x0(); cfg = mk(0,0,1,0,0,0,1,0,2,0,1); #1; clr();
    pin_in = 1; pg1();
    chk("R11 pin captured", reg_out, 1'b1);
    chk("R11 cell_out keeps comb", cell_out, 1'b0);
    sig[0] = 1; #1; chk("R11 comb path live", cell_out, 1'b1);
    pin_in = 0; pg1(); chk("R11 pin captured 0", reg_out, 1'b0);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_sop();
    t_xor();
    t_regsel();
    t_d_g0();
    t_d_fall();
    t_toggle();
    t_latch();
    t_dual();
    t_ce();
    t_clksrc();
    t_setrst();
    t_inreg();
    #(CLK_P);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule